// File: doc/BRIEF.md
# Fixed-Latency Compute Slave with Read Stall

This block puts a fully pipelined compute core of fixed latency behind a single memory-mapped slave port that has a wait-request signal. A master writes an operand to one register. The operand enters a 26-stage pipeline at once, and a new operand can be accepted on every clock. The modelled core adds a constant to each operand.

The master reads the result from a second register. If the operand written most recently is still inside the pipeline, the slave holds wait-request high. It keeps it high until that operand's result reaches the last stage, and then completes the read with that result. Software can therefore issue the read right after the write, with no delay loop. If nothing is in flight, the read completes at once and returns the result that retired last.

Each pipeline stage carries a valid bit and a sequence tag beside the data. The slave can then tell when the newest operand, and not an older one, leaves the pipeline.

Top module: `lat_hide_slave`

## Requirements
- R1: After reset, wait-request is low and a read of the result register (address 1) completes with no wait and returns 0.
- R2: A write to the operand register (address 0) launches the operand. Its result is the operand plus OFFSET (default 32'h0000_1234), taken modulo 2^DATA_W.
- R3: The read of address 1 completes exactly LATENCY (26) clock edges after the edge that accepted the newest write. If the read starts in the cycle after that write, wait-request is high for 25 cycles.
- R4: Wait-request is never high during a write, so the pipeline accepts one operand per clock.
- R5: Back-to-back writes on consecutive clocks are all accepted. A read issued right after them waits for, and returns, the result of the last one.
- R6: A read of address 1 with nothing in flight completes with no wait and returns the most recently retired result, repeatably.
- R7: A read of address 0 returns 0 with no wait. A write to address 1 launches nothing and leaves the result register unchanged.
- R8: If a read starts k idle cycles after the newest write (k < 25), wait-request is high for 25 - k cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register select: 0 operand, 1 result |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe, held by the master while wait-request is high |
| wdata_i | input | DATA_W | Write data (operand) |
| rdata_o | output | DATA_W | Read data, valid when rd_i is high and waitreq_o is low |
| waitreq_o | output | 1 | Stall request for the current read |

## Verification
On every cycle the assertions check four things. Valid bits advance one stage per clock. The newest operand is never tracked as busy for LATENCY cycles or more, and it is marked done in exactly its last busy cycle. Writes are never stalled. A retiring result is captured into the result register. Only the bench scenarios can show the values: the operand plus the constant with wrap-around, the wait counts of 25 and 25 - k, the return of the newest result after a burst, and the handling of the unused direction of each address.

// File: rtl/lat_hide_pkg.sv
package lat_hide_pkg;
  typedef enum logic {
    ADDR_OPND = 1'b0,
    ADDR_RES  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/lh_pipe_stage.sv
module lh_pipe_stage #(
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 6,
  parameter logic [DW-1:0] ADD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v_i,
  input  logic [TW-1:0] tag_i,
  input  logic [DW-1:0] data_i,
  output logic          v_o,
  output logic [TW-1:0] tag_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      tag_o  <= '0;
      data_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        tag_o  <= tag_i;
        data_o <= data_i + ADD;
      end
    end
  end
endmodule

// File: rtl/lh_pipeline.sv
module lh_pipeline #(
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 6,
  parameter int unsigned DEPTH = 26,
  parameter logic [DW-1:0] OFFSET = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v_i,
  input  logic [TW-1:0] tag_i,
  input  logic [DW-1:0] data_i,
  output logic          v_o,
  output logic [TW-1:0] tag_o,
  output logic [DW-1:0] data_o
);
  logic          v_s    [DEPTH+1];
  logic [TW-1:0] tag_s  [DEPTH+1];
  logic [DW-1:0] data_s [DEPTH+1];

  assign v_s[0]    = v_i;
  assign tag_s[0]  = tag_i;
  assign data_s[0] = data_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    // transform applied once, in the first stage
    localparam logic [DW-1:0] StageAdd = (k == 0) ? OFFSET : '0;
    lh_pipe_stage #(.DW(DW), .TW(TW), .ADD(StageAdd)) i_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .v_i   (v_s[k]),
      .tag_i (tag_s[k]),
      .data_i(data_s[k]),
      .v_o   (v_s[k+1]),
      .tag_o (tag_s[k+1]),
      .data_o(data_s[k+1])
    );
  end

  assign v_o    = v_s[DEPTH];
  assign tag_o  = tag_s[DEPTH];
  assign data_o = data_s[DEPTH];

  for (genvar k = 1; k < DEPTH; k++) begin : g_chk
    p_valid_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_s[k] |=> v_s[k+1]);
  end
endmodule

// File: rtl/lh_read_track.sv
module lh_read_track #(
  parameter int unsigned TW = 6,
  parameter int unsigned DEPTH = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          out_v_i,
  input  logic [TW-1:0] out_tag_i,
  output logic [TW-1:0] launch_tag_o,
  output logic          busy_o,
  output logic          done_now_o
);
  localparam int unsigned AW = $clog2(DEPTH + 2);

  logic [TW-1:0] newest_q;
  logic          busy_q;

  assign launch_tag_o = newest_q + 1'b1;
  assign done_now_o   = busy_q && out_v_i && (out_tag_i == newest_q);
  assign busy_o       = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      newest_q <= '0;
      busy_q   <= 1'b0;
    end else if (launch_i) begin
      newest_q <= launch_tag_o;
      busy_q   <= 1'b1;
    end else if (done_now_o) begin
      busy_q <= 1'b0;
    end
  end

  // age of the newest operand, checker only
  logic [AW-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  age_q <= '0;
    else if (launch_i)            age_q <= '0;
    else if (busy_q && age_q < AW'(DEPTH)) age_q <= age_q + 1'b1;
  end

  p_busy_bounded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (age_q < AW'(DEPTH)));
  p_done_on_time_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && age_q == AW'(DEPTH - 1)) |-> done_now_o);
  p_done_not_early_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && age_q < AW'(DEPTH - 1)) |-> !done_now_o);
endmodule

// File: rtl/lat_hide_slave.sv
module lat_hide_slave
  import lat_hide_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LATENCY = 26,
  parameter logic [DATA_W-1:0] OFFSET = 32'h0000_1234
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              waitreq_o
);
  localparam int unsigned TagW = $clog2(LATENCY) + 1;

  logic              launch;
  logic              rd_res;
  logic              rd_opnd;
  logic [TagW-1:0]   launch_tag;
  logic              out_v;
  logic [TagW-1:0]   out_tag;
  logic [DATA_W-1:0] out_data;
  logic              busy;
  logic              done_now;
  logic [DATA_W-1:0] last_res_q;

  assign launch  = wr_i && (reg_sel_e'(addr_i) == ADDR_OPND);
  assign rd_res  = rd_i && (reg_sel_e'(addr_i) == ADDR_RES);
  assign rd_opnd = rd_i && (reg_sel_e'(addr_i) == ADDR_OPND);

  lh_pipeline #(
    .DW(DATA_W), .TW(TagW), .DEPTH(LATENCY), .OFFSET(OFFSET)
  ) i_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (launch),
    .tag_i (launch_tag),
    .data_i(wdata_i),
    .v_o   (out_v),
    .tag_o (out_tag),
    .data_o(out_data)
  );

  lh_read_track #(.TW(TagW), .DEPTH(LATENCY)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .out_v_i     (out_v),
    .out_tag_i   (out_tag),
    .launch_tag_o(launch_tag),
    .busy_o      (busy),
    .done_now_o  (done_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_res_q <= '0;
    else if (out_v) last_res_q <= out_data;
  end

  assign waitreq_o = rd_res && busy && !done_now;

  always_comb begin
    rdata_o = '0;
    if (rd_res) rdata_o = done_now ? out_data : last_res_q;
  end

  p_wr_no_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i) |-> !waitreq_o);
  p_last_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_v |=> (last_res_q == $past(out_data)));
  p_idle_no_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_res && !busy) |-> !waitreq_o);
  p_opnd_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_opnd |-> (!waitreq_o && rdata_o == '0));
endmodule

// File: tb/test_lat_hide_slave.sv
module test_lat_hide_slave;
  localparam int unsigned DW = 32;
  localparam int unsigned LAT = 26;
  localparam logic [DW-1:0] K = 32'h0000_1234;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          addr_i = 1'b0;
  logic          wr_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          waitreq_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk_i = ~clk_i;

  lat_hide_slave #(.DATA_W(DW), .LATENCY(LAT), .OFFSET(K)) i_lat_hide_slave (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .waitreq_o
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives from negedge, returns at the next negedge
  task automatic do_write(input logic a, input logic [DW-1:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    #1;
    check("R4 no wait on write", DW'(waitreq_o), '0);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_read(input logic a, output logic [DW-1:0] d, output int waits);
    waits = 0;
    addr_i = a; rd_i = 1'b1;
    #1;
    while (waitreq_o === 1'b1 && waits < 100) begin
      waits++;
      @(negedge clk_i);
      #1;
    end
    d = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d; int w;
    check("R1 waitreq after reset", DW'(waitreq_o), '0);
    do_read(1'b1, d, w);
    check("R1 reset result", d, '0);
    check("R1 reset read wait", DW'(w), '0);
  endtask

  task automatic t_basic;
    logic [DW-1:0] d; int w;
    do_write(1'b0, 32'h0000_0100);
    do_read(1'b1, d, w);
    check("R2 result value", d, 32'h0000_0100 + K);
    check("R3 wait cycles", DW'(w), DW'(LAT - 1));
  endtask

  task automatic t_partial;
    logic [DW-1:0] d; int w;
    do_write(1'b0, 32'h0000_0ABC);
    idle(10);
    do_read(1'b1, d, w);
    check("R8 wait after 10 idle", DW'(w), DW'(LAT - 1 - 10));
    check("R8 result", d, 32'h0000_0ABC + K);
  endtask

  task automatic t_idle_reread;
    logic [DW-1:0] d; int w;
    for (int i = 0; i < 2; i++) begin
      do_read(1'b1, d, w);
      check("R6 idle result", d, 32'h0000_0ABC + K);
      check("R6 idle wait", DW'(w), '0);
    end
  endtask

  task automatic t_burst;
    logic [DW-1:0] d; int w;
    for (int i = 0; i < int'(LAT); i++) do_write(1'b0, DW'(32'h5000 + i));
    do_read(1'b1, d, w);
    check("R5 burst newest result", d, DW'(32'h5000 + LAT - 1) + K);
    check("R5 burst wait", DW'(w), DW'(LAT - 1));
  endtask

  task automatic t_decode;
    logic [DW-1:0] d; int w;
    do_read(1'b0, d, w);
    check("R7 read addr0 data", d, '0);
    check("R7 read addr0 wait", DW'(w), '0);
    do_write(1'b1, 32'hDEAD_BEEF);
    idle(LAT + 2);
    do_read(1'b1, d, w);
    check("R7 write addr1 ignored", d, DW'(32'h5000 + LAT - 1) + K);
    check("R7 write addr1 no wait", DW'(w), '0);
  endtask

  task automatic t_wrap;
    logic [DW-1:0] d; int w;
    do_write(1'b0, 32'hFFFF_FFFF);
    do_read(1'b1, d, w);
    check("R8 wrap result R2", d, 32'h0000_1233);
    check("R3 wrap wait", DW'(w), DW'(LAT - 1));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_partial();
    t_idle_reread();
    t_burst();
    t_decode();
    t_wrap();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule